// File: doc/BRIEF.md
# Sign-sign LMS tap adaptation engine

This block adjusts the tap weights of a receive equalizer using only signs. Every valid symbol it forms the sign of the error, which is the equalizer output minus the current estimate of the transmitted bit. It multiplies that sign by the sign of the data sample at each tap position. Each tap keeps its weight in a saturating up/down counter. The counter moves one count per symbol in the direction that reduces the error. Only the upper bits of the counter reach the equalizer, so the number of dropped low bits sets the step size.

The engine has two phases. It starts in training mode, where a known pattern supplied from outside serves as the estimate. After a programmable number of valid symbols it moves by itself to decision-directed mode, where the sliced equalizer output serves as the estimate. The error sign comes from two comparator outputs, which tell whether the equalizer output lies above the positive or the negative target level. The engine uses the one that matches the current estimate.

Software-side logic can hold all weights, preset them, or restart training at any time.

Top module: `ssl_tap_adapt`

## Requirements
- R1: After reset every weight reads 0 and `dd_mode` reads 0 (training).
- R2: The estimate bit is `train_bit` while `dd_mode` is 0 and `ysign` while it is 1. The error is positive when the comparator that matches the estimate is 1: `above_hi` for an estimate of 1, `above_lo` for an estimate of 0. A bit value of 1 stands for +1 and 0 stands for -1 throughout.
- R3: On a clock edge with `sym_valid` 1, `freeze` 0 and `load` 0, the counter of tap i moves down by one count when the error sign bit equals `data_hist[i]`, and up by one count when they differ.
- R4: Each tap counter is 10 bits in two's complement. Its upper 8 bits appear as the signed weight of tap i on `weights[8*i+7:8*i]`, so four counts make one weight step.
- R5: Counters saturate at +511 and -512 and never wrap, so weights stop at +127 and -128.
- R6: In training, each valid symbol advances a symbol count. `dd_mode` becomes 1 on the edge that completes `train_len` valid symbols, and the estimate for those symbols is the training bit.
- R7: In decision-directed mode, `ysign` is the estimate, and adaptation continues under the rule of R3.
- R8: While `freeze` is 1 no weight changes. The training symbol count still advances.
- R9: `load` presets counter i to `load_wt[8*i+7:8*i]` times 4, so the weight equals the loaded value after that edge. `load` overrides `freeze` and the update.
- R10: A `train_start` pulse clears the symbol count and returns `dd_mode` to 0 after the edge. It leaves the weights unchanged apart from that cycle's normal update.
- R11: With `sym_valid` 0 and `load` 0, weights and the symbol count do not change.
- R12: With `train_len` 0, the engine enters decision-directed mode on the first edge after a restart, without needing any valid symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| ysign | input | 1 | Sign of the equalizer output (receiver decision) |
| above_hi | input | 1 | Equalizer output is above the positive target level |
| above_lo | input | 1 | Equalizer output is above the negative target level |
| train_bit | input | 1 | Known training bit for this symbol |
| data_hist | input | 4 | Data sign at each tap position, bit i for tap i |
| train_start | input | 1 | Restart training |
| train_len | input | 16 | Number of valid symbols to train for |
| freeze | input | 1 | Hold all weights |
| load | input | 1 | Preset all weights from `load_wt` |
| load_wt | input | 32 | Preset weights, 8 bits per tap |
| weights | output | 32 | Signed tap weights, 8 bits per tap |
| dd_mode | output | 1 | 1 in decision-directed mode, 0 in training |

## Verification
The hardest case to reach from the ports is saturation. A counter must first climb past 511 counts, and then be driven further in the same direction, before the no-wrap rule matters. The stimulus gets there by holding both comparators high and all data bits low for 600 symbols, then reversing both for 1200 symbols. This pins every tap first at +127 and then at -128.

The handover from training to decision-directed mode is also checked on the exact edge, with a random symbol gap pattern. A zero training length is covered as well. Random comparator and data patterns run in both modes, and a behavioural model predicts every weight on every cycle.

// File: rtl/ssl_adapt_pkg.sv
`timescale 1ns/1ps
package ssl_adapt_pkg;
   // direction in which one tap counter moves on a valid symbol
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;
endpackage

// File: rtl/ssl_mode_ctrl.sv
`timescale 1ns/1ps
module ssl_mode_ctrl #(
   parameter int TRAIN_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sym_valid,
   input  logic               train_start,
   input  logic [TRAIN_W-1:0] train_len,
   output logic               dd_mode
);
   logic [TRAIN_W-1:0] sym_cnt;
   logic [TRAIN_W-1:0] cnt_inc;
   logic               dd_q;

   assign cnt_inc = sym_cnt + {{(TRAIN_W-1){1'b0}}, 1'b1};
   assign dd_mode = dd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_cnt <= '0;
         dd_q    <= 1'b0;
      end else if (train_start) begin
         sym_cnt <= '0;
         dd_q    <= 1'b0;
      end else if (!dd_q) begin
         if (sym_cnt >= train_len) begin
            dd_q <= 1'b1;
         end else if (sym_valid) begin
            sym_cnt <= cnt_inc;
            if (cnt_inc >= train_len) dd_q <= 1'b1;
         end
      end
   end

   // R10
   dd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dd_q) |-> $past(train_start));
   // R6
   dd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dd_q) |-> !$past(train_start));
   // R6
   dd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dd_q && !train_start) |=> dd_q);
   // R11
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sym_valid && !train_start) |=> $stable(sym_cnt));
endmodule

// File: rtl/ssl_tap_cnt.sv
`timescale 1ns/1ps
module ssl_tap_cnt
   import ssl_adapt_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int WT_W  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sym_valid,
   input  logic            freeze,
   input  logic            load,
   input  logic [WT_W-1:0] load_wt,
   input  step_e           step,
   output logic [WT_W-1:0] weight
);
   localparam int SHIFT = CNT_W - WT_W;
   localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic signed [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   logic signed [CNT_W-1:0] cnt_q;
   logic signed [CNT_W-1:0] cnt_d;
   logic signed [CNT_W-1:0] preset;

   generate
      if (SHIFT > 0) begin : g_frac
         assign preset = {load_wt, {SHIFT{1'b0}}};
      end else begin : g_full
         assign preset = load_wt;
      end
   endgenerate

   always_comb begin
      cnt_d = cnt_q;
      if (load) begin
         cnt_d = preset;
      end else if (sym_valid && !freeze) begin
         case (step)
            STEP_UP:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + ONE;
            STEP_DOWN: if (cnt_q != CNT_MIN) cnt_d = cnt_q - ONE;
            default:   cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign weight = cnt_q[CNT_W-1 -: WT_W];

   // R5
   no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q) == CNT_MAX && !$past(load)) |-> cnt_q != CNT_MIN);
   // R5
   no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q) == CNT_MIN && !$past(load)) |-> cnt_q != CNT_MAX);
   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE
                        || cnt_q == $past(cnt_q) - ONE));
   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(freeze) && !$past(load)) |-> cnt_q == $past(cnt_q));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sym_valid) && !$past(load)) |-> $stable(cnt_q));
   // R9
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> weight == $past(load_wt));
endmodule

// File: rtl/ssl_tap_adapt.sv
`timescale 1ns/1ps
module ssl_tap_adapt
   import ssl_adapt_pkg::*;
#(
   parameter int NTAPS   = 4,
   parameter int CNT_W   = 10,
   parameter int WT_W    = 8,
   parameter int TRAIN_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sym_valid,
   input  logic                  ysign,
   input  logic                  above_hi,
   input  logic                  above_lo,
   input  logic                  train_bit,
   input  logic [NTAPS-1:0]      data_hist,
   input  logic                  train_start,
   input  logic [TRAIN_W-1:0]    train_len,
   input  logic                  freeze,
   input  logic                  load,
   input  logic [NTAPS*WT_W-1:0] load_wt,
   output logic [NTAPS*WT_W-1:0] weights,
   output logic                  dd_mode
);
   generate
      if (WT_W > CNT_W || WT_W < 2) begin : g_bad_width
         $error("ssl_tap_adapt: WT_W must lie in 2..CNT_W");
      end
      if (NTAPS < 1) begin : g_bad_taps
         $error("ssl_tap_adapt: NTAPS must be at least 1");
      end
   endgenerate

   logic  ref_bit;
   logic  err_pos;
   step_e tap_step [NTAPS];

   ssl_mode_ctrl #(.TRAIN_W(TRAIN_W)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_valid   (sym_valid),
      .train_start (train_start),
      .train_len   (train_len),
      .dd_mode     (dd_mode)
   );

   // estimate of the sent bit, then the comparator that matches it
   assign ref_bit = dd_mode ? ysign : train_bit;
   assign err_pos = ref_bit ? above_hi : above_lo;

   generate
      for (genvar g = 0; g < NTAPS; g++) begin : g_tap
         assign tap_step[g] = (err_pos == data_hist[g]) ? STEP_DOWN : STEP_UP;

         ssl_tap_cnt #(.CNT_W(CNT_W), .WT_W(WT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .sym_valid (sym_valid),
            .freeze    (freeze),
            .load      (load),
            .load_wt   (load_wt[g*WT_W +: WT_W]),
            .step      (tap_step[g]),
            .weight    (weights[g*WT_W +: WT_W])
         );
      end
   endgenerate
endmodule

// File: tb/ssl_tap_adapt_test.sv
`timescale 1ns/1ps
module ssl_tap_adapt_test;
   localparam int NT = 4;
   localparam int WW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sym_valid = 1'b0;
   logic            ysign = 1'b0;
   logic            above_hi = 1'b0;
   logic            above_lo = 1'b0;
   logic            train_bit = 1'b0;
   logic [NT-1:0]   data_hist = '0;
   logic            train_start = 1'b0;
   logic [15:0]     train_len = 16'd0;
   logic            freeze = 1'b0;
   logic            load = 1'b0;
   logic [NT*WW-1:0] load_wt = '0;
   logic [NT*WW-1:0] weights;
   logic            dd_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   integer mc [NT];
   integer m_cnt;
   bit     m_dd;

   ssl_tap_adapt uut (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .ysign(ysign),
      .above_hi(above_hi), .above_lo(above_lo), .train_bit(train_bit),
      .data_hist(data_hist), .train_start(train_start), .train_len(train_len),
      .freeze(freeze), .load(load), .load_wt(load_wt),
      .weights(weights), .dd_mode(dd_mode)
   );

   always #10 clk = ~clk;

   task automatic check_val(string tag, integer got, integer exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic compare(string tag);
      integer g;
      for (int i = 0; i < NT; i++) begin
         g = $signed(weights[i*WW +: WW]);
         check_val(tag, g, mc[i] >>> 2);
      end
      check_val({tag, " mode"}, integer'(dd_mode), integer'(m_dd));
   endtask

   task automatic model_update();
      logic   rb;
      logic   ep;
      integer v;
      rb = m_dd ? ysign : train_bit;
      ep = rb ? above_hi : above_lo;
      for (int i = 0; i < NT; i++) begin
         if (load) begin
            v = $signed(load_wt[i*WW +: WW]);
            mc[i] = v * 4;
         end else if (sym_valid && !freeze) begin
            if (ep == data_hist[i]) begin
               if (mc[i] > -512) mc[i] = mc[i] - 1;
            end else begin
               if (mc[i] < 511) mc[i] = mc[i] + 1;
            end
         end
      end
      if (train_start) begin
         m_cnt = 0;
         m_dd  = 1'b0;
      end else if (!m_dd) begin
         if (m_cnt >= int'(train_len)) m_dd = 1'b1;
         else if (sym_valid) begin
            m_cnt = m_cnt + 1;
            if (m_cnt >= int'(train_len)) m_dd = 1'b1;
         end
      end
   endtask

   task automatic tick(string tag);
      model_update();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic rand_inputs(int valid_pct);
      logic [31:0] r;
      r = $urandom;
      sym_valid = (r[6:0] % 100) < valid_pct;
      ysign     = r[8];
      above_hi  = r[9];
      above_lo  = r[10];
      train_bit = r[11];
      data_hist = r[15:12];
   endtask

   initial begin
      for (int i = 0; i < NT; i++) mc[i] = 0;
      m_cnt = 0;
      m_dd  = 1'b0;
      repeat (2) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;

      // training with gaps, handover on the exact edge
      train_len = 16'd20;
      for (int c = 0; c < 60; c++) begin
         rand_inputs(75);
         tick("R2/R3/R4/R6 training");
      end
      // decision-directed adaptation
      for (int c = 0; c < 100; c++) begin
         rand_inputs(90);
         tick("R7 decision-directed");
      end
      // drive every tap to the upper limit, then the lower one
      sym_valid = 1'b1; above_hi = 1'b1; above_lo = 1'b1; data_hist = '0;
      for (int c = 0; c < 600; c++) tick("R5 climb");
      for (int i = 0; i < NT; i++)
         check_val("R5 upper limit", $signed(weights[i*WW +: WW]), 127);
      above_hi = 1'b0; above_lo = 1'b0;
      for (int c = 0; c < 1200; c++) tick("R5 descend");
      for (int i = 0; i < NT; i++)
         check_val("R5 lower limit", $signed(weights[i*WW +: WW]), -128);
      // freeze holds weights
      freeze = 1'b1;
      for (int c = 0; c < 50; c++) begin
         rand_inputs(100);
         tick("R8 freeze");
      end
      // preset, with and without freeze
      for (int c = 0; c < 10; c++) begin
         rand_inputs(100);
         freeze  = c[0];
         load    = 1'b1;
         load_wt = $urandom;
         tick("R9 load");
         for (int i = 0; i < NT; i++)
            check_val("R9 loaded weight", $signed(weights[i*WW +: WW]),
                      $signed(load_wt[i*WW +: WW]));
      end
      freeze = 1'b0;
      for (int c = 0; c < 60; c++) begin
         rand_inputs(80);
         load    = ($urandom % 8) == 0;
         load_wt = $urandom;
         tick("R9 mixed");
      end
      load = 1'b0;
      // no valid symbol: nothing moves
      for (int c = 0; c < 50; c++) begin
         rand_inputs(0);
         tick("R11 idle");
      end
      // zero training length
      train_len = 16'd0;
      train_start = 1'b1;
      rand_inputs(0);
      tick("R12 restart");
      check_val("R12 training after restart", integer'(dd_mode), 0);
      train_start = 1'b0;
      tick("R12 zero length");
      check_val("R12 immediate handover", integer'(dd_mode), 1);
      // restart mid-run keeps weights
      train_len = 16'd7;
      train_start = 1'b1;
      rand_inputs(100);
      tick("R10 restart");
      check_val("R10 back to training", integer'(dd_mode), 0);
      train_start = 1'b0;
      for (int c = 0; c < 40; c++) begin
         rand_inputs(70);
         tick("R10 retrain");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule